// File: doc/BRIEF.md
# Converter Fault and Hiccup Sequencer

This block is the digital supervisor that sits beside a buck converter's PWM loop. It takes comparator flags from the analog front end: two input-supply flags that form an undervoltage window, an over-current flag and a junction-temperature code. It also takes an already-registered enable. From these it decides when the power stage may switch. When switching is not allowed it forces the high-side switch off. During an over-current retry it also forces the low-side switch on. Each time the stage is allowed to start, it issues a one-cycle request that restarts the soft-start ramp.

An over-current event empties the output through the low-side switch for a fixed hold time, nominally 1 ms, counted in clock ticks. After the hold, a fresh soft-start begins. If the over-current is still present, the same cycle repeats without limit. A low enable, a supply undervoltage or a thermal trip outranks the over-current retry and cancels a hold that is in progress.

The undervoltage lockout and the thermal shutdown both use hysteresis, so the converter does not chatter when a supply or temperature sits near a threshold. Every comparator input passes through a synchronizer before it is used.

Top module: `fhs_seq`

## Requirements
- R1: While reset is asserted and directly after its release, the outputs read sw_en_o=0, hs_off_o=1, ls_on_o=0 and ss_start_o=0. The undervoltage lockout starts in the locked state.
- R2: When en_i is low, the stage is shut down: sw_en_o=0, ls_on_o=0, hs_off_o=1. This takes effect at the first clock edge that samples en_i low.
- R3: The undervoltage lockout engages when vin_below_off_i is 1 and releases only when vin_above_on_i is 1. With both flags at 0 the lockout keeps its last state. While the lockout is engaged, sw_en_o=0.
- R4: Thermal shutdown engages when temp_code_i >= TEMP_TRIP (unsigned). It releases only when temp_code_i <= TEMP_TRIP-TEMP_HYST. Between those values it keeps its last state. While engaged, sw_en_o=0 and ls_on_o=0.
- R5: oc_i high while running gives hs_off_o=1 and ls_on_o=1 for exactly HOLD_TICKS = (CLK_HZ/1e6)*HOLD_US consecutive cycles. oc_i is ignored during the hold.
- R6: When the hold ends, the stage returns to running with a soft-start request. If oc_i is still high, the next hold starts one cycle later, and this repeats without limit.
- R7: Priority is enable low, then undervoltage, then thermal, then over-current. A higher-priority condition cancels a hold in progress, which drops ls_on_o.
- R8: ss_start_o is high for exactly one cycle, namely the first cycle of each running period, and is never high at any other time.
- R9: sw_en_o and ls_on_o are never high together, and hs_off_o is 1 whenever sw_en_o is 0.
- R10: Latency from an input change to the outputs is counted in clock edges. For en_i it is 1 edge. For oc_i it is SYNC_STAGES+1 edges. For the supply flags and temp_code_i it is SYNC_STAGES+2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Registered converter enable, high to run |
| vin_below_off_i | input | 1 | Supply below the falling lockout threshold |
| vin_above_on_i | input | 1 | Supply above the rising release threshold |
| oc_i | input | 1 | High-side over-current comparator flag |
| temp_code_i | input | TEMP_W | Junction temperature code, unsigned degrees |
| sw_en_o | output | 1 | PWM switching permitted |
| hs_off_o | output | 1 | Force high-side switch off |
| ls_on_o | output | 1 | Force low-side switch on |
| ss_start_o | output | 1 | One-cycle soft-start restart request |

## Verification
The bench builds the block with CLK_HZ=10 MHz and HOLD_US=2. This shrinks the hold to 20 ticks, so complete hold periods, back-to-back retries and holds cancelled partway through all fit in a few thousand cycles. SYNC_STAGES stays at 2, which fixes the edge counts the bench relies on. TEMP_TRIP=150 and TEMP_HYST=15 place the thermal window at 135..149, where the boundary codes are driven both directly and at random.

// File: rtl/fhs_pkg.sv
package fhs_pkg;

   typedef enum logic [2:0] {
      FS_OFF  = 3'd0,
      FS_LOCK = 3'd1,
      FS_HOT  = 3'd2,
      FS_HOLD = 3'd3,
      FS_RUN  = 3'd4
   } fhs_state_e;

   // bit positions inside the synchronized flag bundle
   localparam int unsigned FLG_OC    = 0;
   localparam int unsigned FLG_ABOVE = 1;
   localparam int unsigned FLG_BELOW = 2;
   localparam int unsigned FLG_W     = 3;

   function automatic int unsigned ticks_for(input int unsigned clk_hz,
                                             input int unsigned hold_us);
      return (clk_hz / 1_000_000) * hold_us;
   endfunction

endpackage

// File: rtl/fhs_sync.sv
module fhs_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("fhs_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/fhs_uvlo.sv
module fhs_uvlo (
   input  logic clk,
   input  logic rst_n,
   input  logic below_off,
   input  logic above_on,
   output logic locked
);

   // engage wins over release if the flags ever disagree
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         locked <= 1'b1;
      else if (below_off) locked <= 1'b1;
      else if (above_on)  locked <= 1'b0;
   end

endmodule

// File: rtl/fhs_thermal.sv
module fhs_thermal #(
   parameter int unsigned TEMP_W    = 8,
   parameter int unsigned TEMP_TRIP = 150,
   parameter int unsigned TEMP_HYST = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp,
   output logic              hot
);

   localparam int unsigned RELEASE = TEMP_TRIP - TEMP_HYST;
   localparam logic [TEMP_W-1:0] TRIP_C = TEMP_W'(TEMP_TRIP);
   localparam logic [TEMP_W-1:0] REL_C  = TEMP_W'(RELEASE);

   generate
      if (TEMP_HYST == 0 || TEMP_HYST > TEMP_TRIP) begin : g_bad_hyst
         $error("fhs_thermal: TEMP_HYST must be in 1..TEMP_TRIP");
      end
      if (TEMP_TRIP >= (1 << TEMP_W)) begin : g_bad_trip
         $error("fhs_thermal: TEMP_TRIP does not fit TEMP_W");
      end
   endgenerate

   logic trip_now, cool_now;
   assign trip_now = (temp >= TRIP_C);
   assign cool_now = (temp <= REL_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hot <= 1'b0;
      else if (trip_now) hot <= 1'b1;
      else if (cool_now) hot <= 1'b0;
   end

endmodule

// File: rtl/fhs_hold_timer.sv
module fhs_hold_timer #(
   parameter int unsigned TICKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic active,
   output logic expired
);

   generate
      if (TICKS == 0) begin : g_bad
         $error("fhs_hold_timer: TICKS must be at least 1");
      end
      if (TICKS == 1) begin : g_single
         // a one-tick hold needs no counter
         assign expired = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(TICKS);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt <= '0;
            else if (load)                cnt <= CW'(TICKS - 1);
            else if (active && cnt != '0) cnt <= cnt - 1'b1;
         end
         assign expired = (cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/fhs_seq.sv
module fhs_seq
   import fhs_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned HOLD_US     = 1000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TEMP_W      = 8,
   parameter int unsigned TEMP_TRIP   = 150,
   parameter int unsigned TEMP_HYST   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              vin_below_off_i,
   input  logic              vin_above_on_i,
   input  logic              oc_i,
   input  logic [TEMP_W-1:0] temp_code_i,
   output logic              sw_en_o,
   output logic              hs_off_o,
   output logic              ls_on_o,
   output logic              ss_start_o
);

   localparam int unsigned HOLD_TICKS = ticks_for(CLK_HZ, HOLD_US);

   generate
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("fhs_seq: CLK_HZ and HOLD_US give a zero-length hold");
      end
   endgenerate

   // ---------------- input synchronizers ----------------
   logic [FLG_W-1:0]  flg_raw, flg_s;
   logic [TEMP_W-1:0] temp_s;

   always_comb begin
      flg_raw            = '0;
      flg_raw[FLG_OC]    = oc_i;
      flg_raw[FLG_ABOVE] = vin_above_on_i;
      flg_raw[FLG_BELOW] = vin_below_off_i;
   end

   fhs_sync #(.W(FLG_W), .STAGES(SYNC_STAGES)) u_sync_flg (
      .clk (clk),
      .rst_n (rst_n),
      .d (flg_raw),
      .q (flg_s)
   );

   fhs_sync #(.W(TEMP_W), .STAGES(SYNC_STAGES)) u_sync_temp (
      .clk (clk),
      .rst_n (rst_n),
      .d (temp_code_i),
      .q (temp_s)
   );

   // ---------------- condition detectors ----------------
   logic uv_locked, th_hot;

   fhs_uvlo u_uvlo (
      .clk (clk),
      .rst_n (rst_n),
      .below_off (flg_s[FLG_BELOW]),
      .above_on (flg_s[FLG_ABOVE]),
      .locked (uv_locked)
   );

   fhs_thermal #(
      .TEMP_W (TEMP_W),
      .TEMP_TRIP (TEMP_TRIP),
      .TEMP_HYST (TEMP_HYST)
   ) u_thermal (
      .clk (clk),
      .rst_n (rst_n),
      .temp (temp_s),
      .hot (th_hot)
   );

   // ---------------- sequencer ----------------
   fhs_state_e st, nxt;
   logic       hold_load, hold_done, ss_q;

   always_comb begin
      nxt = st;
      if (!en_i) begin
         nxt = FS_OFF;
      end else if (uv_locked) begin
         nxt = FS_LOCK;
      end else if (th_hot) begin
         nxt = FS_HOT;
      end else begin
         unique case (st)
            FS_OFF, FS_LOCK, FS_HOT: nxt = FS_RUN;
            FS_RUN:  if (flg_s[FLG_OC]) nxt = FS_HOLD;
            FS_HOLD: if (hold_done)     nxt = FS_RUN;
            default: nxt = FS_OFF;
         endcase
      end
   end

   assign hold_load = (nxt == FS_HOLD) && (st != FS_HOLD);

   fhs_hold_timer #(.TICKS(HOLD_TICKS)) u_hold (
      .clk (clk),
      .rst_n (rst_n),
      .load (hold_load),
      .active (st == FS_HOLD),
      .expired (hold_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= FS_OFF;
         ss_q <= 1'b0;
      end else begin
         st   <= nxt;
         ss_q <= (nxt == FS_RUN) && (st != FS_RUN);
      end
   end

   assign sw_en_o    = (st == FS_RUN);
   assign hs_off_o   = (st != FS_RUN);
   assign ls_on_o    = (st == FS_HOLD);
   assign ss_start_o = ss_q;

endmodule

// File: rtl/fhs_seq_chk.sv
module fhs_seq_chk #(
   parameter int unsigned CLK_HZ  = 100_000_000,
   parameter int unsigned HOLD_US = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic sw_en_o,
   input logic hs_off_o,
   input logic ls_on_o,
   input logic ss_start_o
);

   localparam int unsigned HOLD_TICKS = fhs_pkg::ticks_for(CLK_HZ, HOLD_US);
   localparam int unsigned CW = $clog2(HOLD_TICKS + 2);

   // cycles of low-side forcing seen before the current one
   logic [CW-1:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_len <= '0;
      else if (ls_on_o) run_len <= run_len + 1'b1;
      else              run_len <= '0;
   end

   AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      ls_on_o |-> (run_len < CW'(HOLD_TICKS)));                        // R5
   AST_EN_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!sw_en_o && !ls_on_o));                              // R2
   AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_en_o && ls_on_o));                                         // R9
   AST_HS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en_o |-> hs_off_o);                                         // R9
   AST_SS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ss_start_o |=> !ss_start_o);                                    // R8
   AST_SS_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ss_start_o |-> $rose(sw_en_o));                                 // R8
   AST_ENTRY_HAS_SS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en_o) |-> ss_start_o);                                 // R8

endmodule

bind fhs_seq fhs_seq_chk #(.CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US)) u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .en_i (en_i),
   .sw_en_o (sw_en_o),
   .hs_off_o (hs_off_o),
   .ls_on_o (ls_on_o),
   .ss_start_o (ss_start_o)
);

// File: tb/fhs_seq_tb.sv
`timescale 1ns/1ps
module fhs_seq_tb;

   localparam int unsigned CLK_HZ = 10_000_000;
   localparam int unsigned HOLD_US = 2;
   localparam int unsigned HT = (CLK_HZ / 1_000_000) * HOLD_US;   // 20
   localparam int unsigned TRIP = 150;
   localparam int unsigned REL = 135;

   // expected {sw_en, hs_off, ls_on, ss_start}
   localparam logic [3:0] E_IDLE = 4'b0100;
   localparam logic [3:0] E_RSS  = 4'b1001;
   localparam logic [3:0] E_RUN  = 4'b1000;
   localparam logic [3:0] E_HOLD = 4'b0110;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, below = 1'b1, above = 1'b0, oc = 1'b0;
   logic [7:0] temp = 8'd25;
   logic sw, hs, ls, ss;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fhs_seq #(
      .CLK_HZ (CLK_HZ),
      .HOLD_US (HOLD_US),
      .SYNC_STAGES (2),
      .TEMP_W (8),
      .TEMP_TRIP (TRIP),
      .TEMP_HYST (15)
   ) u_dut (
      .clk (clk),
      .rst_n (rst_n),
      .en_i (en),
      .vin_below_off_i (below),
      .vin_above_on_i (above),
      .oc_i (oc),
      .temp_code_i (temp),
      .sw_en_o (sw),
      .hs_off_o (hs),
      .ls_on_o (ls),
      .ss_start_o (ss)
   );

   // ---------------- requirement-level reference model ----------------
   logic [2:0] m_s1, m_s2;             // {below, above, oc}
   logic [7:0] m_t1, m_t2;
   logic       m_lock, m_hot, m_ss;
   int         m_st, m_nx, m_h;        // 0 off 1 lock 2 hot 3 hold 4 run

   always_comb begin
      m_nx = m_st;
      if (!en)          m_nx = 0;
      else if (m_lock)  m_nx = 1;
      else if (m_hot)   m_nx = 2;
      else if (m_st <= 2) m_nx = 4;
      else if (m_st == 4) m_nx = m_s2[0] ? 3 : 4;
      else              m_nx = (m_h == int'(HT) - 1) ? 4 : 3;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_t1 <= '0; m_t2 <= '0;
         m_lock <= 1'b1; m_hot <= 1'b0; m_ss <= 1'b0; m_st <= 0; m_h <= 0;
      end else begin
         m_s1 <= {below, above, oc};
         m_s2 <= m_s1;
         m_t1 <= temp;
         m_t2 <= m_t1;
         if (m_s2[2])      m_lock <= 1'b1;
         else if (m_s2[1]) m_lock <= 1'b0;
         if (m_t2 >= 8'(TRIP))     m_hot <= 1'b1;
         else if (m_t2 <= 8'(REL)) m_hot <= 1'b0;
         m_ss <= (m_nx == 4) && (m_st != 4);
         m_h  <= (m_nx == 3 && m_st == 3) ? m_h + 1 : 0;
         m_st <= m_nx;
      end
   end

   function automatic logic [3:0] model_out(int st, logic ssv);
      return {st == 4, st != 4, st == 3, ssv};
   endfunction

   // ---------------- helpers ----------------
   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [3:0] exp);
      checks++;
      if ({sw, hs, ls, ss} !== exp) begin
         errors++;
         $display("FAIL %s t=%0t actual {sw,hs,ls,ss}=%b expected %b",
                  req, $time, {sw, hs, ls, ss}, exp);
      end
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7331));
      step(3);
      chk("R1 in reset", E_IDLE);
      rst_n = 1'b1;
      #1;
      chk("R1 after release", E_IDLE);
      step(2);
      chk("R2 en low idle", E_IDLE);

      // R3: lockout starts engaged, releases only on above flag
      en = 1'b1;
      step(1);
      chk("R3 locked at start", E_IDLE);
      below = 1'b0;
      step(10);
      chk("R3 hold lock between thresholds", E_IDLE);
      above = 1'b1;
      step(3);
      chk("R10 uv release latency not yet", E_IDLE);
      step(1);
      chk("R3 release and soft start", E_RSS);
      step(1);
      chk("R8 ss pulse one cycle", E_RUN);
      above = 1'b0;
      step(10);
      chk("R3 stay released between thresholds", E_RUN);
      below = 1'b1;
      step(3);
      chk("R10 uv engage latency not yet", E_RUN);
      step(1);
      chk("R3 engage lockout", E_IDLE);
      below = 1'b0;
      step(10);
      chk("R3 stay locked between thresholds", E_IDLE);
      above = 1'b1;
      step(4);
      chk("R3 release again", E_RSS);

      // R4 thermal window
      temp = 8'd149;
      step(6);
      chk("R4 149 below trip", E_RUN);
      temp = 8'd150;
      step(3);
      chk("R10 thermal latency not yet", E_RUN);
      step(1);
      chk("R4 trip at 150", E_IDLE);
      temp = 8'd136;
      step(10);
      chk("R4 136 keeps shutdown", E_IDLE);
      temp = 8'd135;
      step(3);
      chk("R4 release latency not yet", E_IDLE);
      step(1);
      chk("R4 release at 135", E_RSS);

      // R5/R6 hiccup
      oc = 1'b1;
      step(2);
      chk("R10 oc latency not yet", E_RUN);
      step(1);
      chk("R5 hold begins", E_HOLD);
      for (int i = 1; i < int'(HT); i++) begin
         step(1);
         chk("R5 hold continues", E_HOLD);
      end
      step(1);
      chk("R6 hold ends with soft start", E_RSS);
      step(1);
      chk("R6 retry while oc persists", E_HOLD);
      oc = 1'b0;
      step(int'(HT) - 1);
      chk("R5 oc ignored in hold", E_HOLD);
      step(1);
      chk("R6 restart after hold", E_RSS);
      step(10);
      chk("R6 stays running once clear", E_RUN);

      // R7 cancel by enable
      oc = 1'b1;
      step(3);
      chk("R5 hold for abort", E_HOLD);
      step(5);
      en = 1'b0;
      step(1);
      chk("R7 enable cancels hold", E_IDLE);
      en = 1'b1;
      step(1);
      chk("R2 enable restarts soft start", E_RSS);
      step(1);
      chk("R6 oc still present", E_HOLD);
      step(3);
      temp = 8'd160;
      step(3);
      chk("R7 hold before thermal", E_HOLD);
      step(1);
      chk("R7 thermal cancels hold", E_IDLE);
      oc = 1'b0;
      temp = 8'd100;
      step(3);
      chk("R4 still hot", E_IDLE);
      step(1);
      chk("R4 cool restart", E_RSS);
      step(5);
      chk("R6 running", E_RUN);
      en = 1'b0;
      step(1);
      chk("R2 en low from run", E_IDLE);
      step(1);
      chk("R2 stays off", E_IDLE);
      en = 1'b1;
      step(1);
      chk("R8 re-entry pulse", E_RSS);

      // random phase against the reference model
      for (int c = 0; c < 3000; c++) begin
         if ($urandom_range(0, 39) == 0) en = ~en;
         if ($urandom_range(0, 59) == 0) below = 1'b1;
         else if ($urandom_range(0, 9) == 0) below = 1'b0;
         if ($urandom_range(0, 19) == 0) above = ~above;
         if ($urandom_range(0, 29) == 0) oc = ~oc;
         if ($urandom_range(0, 49) == 0) begin
            case ($urandom_range(0, 5))
               0: temp = 8'd100;
               1: temp = 8'd134;
               2: temp = 8'd135;
               3: temp = 8'd149;
               4: temp = 8'd150;
               default: temp = 8'd200;
            endcase
         end
         step(1);
         chk("R10 random vs model", model_out(m_st, m_ss));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule